// File: doc/BRIEF.md
# Watchdog Timer with Reset-Source Flag

An 8-bit up-counter advances once per prescaled tick. The tick is the peripheral clock divided by one of eight fixed ratios. When the counter wraps from all-ones to zero, an overflow flag is set. What else happens depends on the mode. In interval mode the flag drives an interrupt request. In watchdog mode, with reset-on-overflow enabled, the overflow instead produces a one-clock internal reset pulse.

Software keeps a watchdog quiet by rewriting the counter before it wraps. A small system-control register sits beside the timer. Its bit 3 is a read-only record of where the last reset came from. The external reset input sets it to 1. A watchdog-generated reset clears it to 0.

Registers are reached through a single-cycle write port and a combinational read port:
- Address 0 is control.
- Address 1 is the counter.
- Address 2 is system control.
- Address 3 reads as zero.

Top module: `wdt_rstflag`

## Requirements
- R1: While `ext_rst_n` is low, and just after it, control reads 0x00, the counter reads 0x00, system control reads 0x09, and `irq` and `int_rst` are 0.
- R2: Control bits [2:0] select the tick divider. Codes 0 to 7 give 2, 32, 64, 128, 256, 512, 2048 and 4096. The counter advances by one every divider-count clocks while running.
- R3: When a tick takes the counter from 0xFF to 0x00, the overflow flag (control bit 7) is set.
- R4: In interval mode (control bit 6 = 0), `irq` is high exactly while the overflow flag is set.
- R5: In watchdog mode (bit 6 = 1) with reset-on-overflow (bit 3 = 1), an overflow drives `int_rst` high for exactly one clock, on the clock after the wrap. `irq` stays low.
- R6: The reset-source bit (system control bit 3) is 1 after an external reset. A watchdog reset clears it. Writes to it have no effect.
- R7: The overflow flag clears only when control is written with bit 7 = 0. Writing 1 to bit 7 leaves it unchanged.
- R8: While the run bit (control bit 5) is 0, the counter holds 0x00, the prescaler is cleared, and counter writes are ignored.
- R9: A counter write loads the written value and wins over a tick in the same cycle. Periodic rewrites prevent any overflow, interrupt or internal reset.
- R10: System control bits other than bit 3 hold whatever was last written.
- R11: In watchdog mode with reset-on-overflow at 0, an overflow sets the flag. It raises neither `irq` nor `int_rst`, and the reset-source bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| ext_rst_n | input | 1 | External reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interval-mode overflow interrupt request |
| int_rst | output | 1 | One-clock internal reset pulse |

## Verification
The bench builds the block with its default widths: an 8-bit counter and a 12-bit prescaler. With these widths, every one of the eight dividers can be reached in a few thousand clocks by preloading the counter to 0xFE before each wrap. A behavioural model predicts the read data, `irq` and `int_rst` on every clock. This exposes any off-by-one in a divider, in the wrap, or in the timing of the reset pulse.

// File: rtl/wdt_rstflag.sv
module wdt_rstflag #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 12
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       int_rst
);

  function automatic logic [PSC_W-1:0] last_of(input logic [2:0] sel);
    case (sel)
      3'd0:    last_of = PSC_W'(1);
      3'd1:    last_of = PSC_W'(31);
      3'd2:    last_of = PSC_W'(63);
      3'd3:    last_of = PSC_W'(127);
      3'd4:    last_of = PSC_W'(255);
      3'd5:    last_of = PSC_W'(511);
      3'd6:    last_of = PSC_W'(2047);
      default: last_of = PSC_W'(4095);
    endcase
  endfunction

  logic [2:0]       cks;
  logic             run, wdmode, rsten, ovf, src;
  logic [CNT_W-1:0] cnt;
  logic [PSC_W-1:0] psc;
  logic [3:0]       sys_hi;
  logic [2:0]       sys_lo;

  wire wr_ctrl = wr_en && (addr == 2'd0);
  wire kick    = wr_en && (addr == 2'd1);
  wire wr_sys  = wr_en && (addr == 2'd2);
  wire tick    = run && (psc >= last_of(cks));
  wire wrap    = tick && (cnt == '1) && !kick;
  wire wd_fire = wrap && wdmode && rsten;

  always_ff @(posedge clk) begin
    if (!ext_rst_n) begin
      psc     <= '0;
      cnt     <= '0;
      cks     <= '0;
      run     <= 1'b0;
      wdmode  <= 1'b0;
      rsten   <= 1'b0;
      ovf     <= 1'b0;
      src     <= 1'b1;
      int_rst <= 1'b0;
      sys_hi  <= '0;
      sys_lo  <= 3'b001;
    end else begin
      psc <= (!run || tick) ? '0 : psc + 1'b1;

      if (!run)      cnt <= '0;
      else if (kick) cnt <= wdata[CNT_W-1:0];
      else if (tick) cnt <= cnt + 1'b1;

      if (wrap)                     ovf <= 1'b1;
      else if (wr_ctrl && !wdata[7]) ovf <= 1'b0;

      if (wr_ctrl) begin
        wdmode <= wdata[6];
        run    <= wdata[5];
        rsten  <= wdata[3];
        cks    <= wdata[2:0];
      end

      int_rst <= wd_fire;
      if (wd_fire) src <= 1'b0;

      if (wr_sys) begin
        sys_hi <= wdata[7:4];
        sys_lo <= wdata[2:0];
      end
    end
  end

  assign irq = ovf && !wdmode;

  always_comb begin
    case (addr)
      2'd0:    rdata = {ovf, wdmode, run, 1'b0, rsten, cks};
      2'd1:    rdata = 8'(cnt);
      2'd2:    rdata = {sys_hi, src, sys_lo};
      default: rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/wdt_rstflag_chk.sv
module wdt_rstflag_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wdmode,
  input logic             rsten,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             src,
  input logic             irq,
  input logic             int_rst
);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> !int_rst);

  p_pulse_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> ($past(wdmode) && $past(rsten)));

  p_src_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src) |-> int_rst);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  p_flag_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (cnt == '0));

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdmode |-> !irq);

endmodule

bind wdt_rstflag wdt_rstflag_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(ext_rst_n), .run(run), .wdmode(wdmode), .rsten(rsten),
  .cnt(cnt), .ovf(ovf), .src(src), .irq(irq), .int_rst(int_rst)
);

// File: tb/sim_wdt_rstflag.sv
module sim_wdt_rstflag;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, int_rst;

  int vecs = 0, bad = 0;

  wdt_rstflag u0 (.clk(clk), .ext_rst_n(ext_rst_n), .wr_en(wr_en), .addr(addr),
                  .wdata(wdata), .rdata(rdata), .irq(irq), .int_rst(int_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_psc = 0, m_cnt = 0, m_cks = 0;
  bit m_run = 0, m_wd = 0, m_rsten = 0, m_flag = 0, m_src = 1, m_pulse = 0;
  int m_sys = 'h09;

  function automatic int ratio(int c);
    case (c)
      0: return 2;    1: return 32;   2: return 64;   3: return 128;
      4: return 256;  5: return 512;  6: return 2048; default: return 4096;
    endcase
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return (m_flag << 7) | (m_wd << 6) | (m_run << 5) | (m_rsten << 3) | m_cks;
      1: return m_cnt;
      2: return (m_sys & 'hF7) | (m_src << 3);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!ext_rst_n) begin
      m_psc = 0; m_cnt = 0; m_cks = 0; m_run = 0; m_wd = 0; m_rsten = 0;
      m_flag = 0; m_src = 1; m_pulse = 0; m_sys = 'h09;
    end else begin
      bit tk, kick, ov, fire;
      tk   = m_run && (m_psc >= ratio(m_cks) - 1);
      kick = wr_en && addr == 1;
      ov   = tk && m_cnt == 255 && !kick;
      fire = ov && m_wd && m_rsten;
      m_psc = (!m_run || tk) ? 0 : m_psc + 1;
      if (!m_run)    m_cnt = 0;
      else if (kick) m_cnt = wdata;
      else if (tk)   m_cnt = (m_cnt + 1) % 256;
      if (ov) m_flag = 1;
      else if (wr_en && addr == 0 && !wdata[7]) m_flag = 0;
      if (wr_en && addr == 0) begin
        m_wd = wdata[6]; m_run = wdata[5]; m_rsten = wdata[3]; m_cks = wdata[2:0];
      end
      if (fire) m_src = 0;
      m_pulse = fire;
      if (wr_en && addr == 2) m_sys = wdata;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    chk("R4 irq", irq, m_flag && !m_wd);
    chk("R5 int_rst", int_rst, m_pulse);
    chk("R2 rdata", rdata, exp_rd(addr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; addr = 2'(a); wdata = 8'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic peek(int a);
    addr = 2'(a);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int pulses, irqs;
    idle(3);
    peek(2); chk("R1 sysctl", rdata, 'h09);
    peek(1); chk("R1 count", rdata, 0);
    peek(0); chk("R1 ctrl", rdata, 0);
    chk("R1 irq", irq, 0); chk("R1 int_rst", int_rst, 0);
    ext_rst_n = 1;
    idle(2);

    wr(1, 'h55); peek(1); chk("R8 write ignored", rdata, 0);
    idle(5); chk("R8 hold", rdata, 0);

    wr(0, 'h20); idle(520);
    peek(0); chk("R3 flag", rdata[7], 1); chk("R4 irq", irq, 1);
    wr(0, 'hA0); chk("R7 write one keeps", rdata[7], 1);
    wr(0, 'h20); chk("R7 write zero clears", rdata[7], 0); chk("R7 irq", irq, 0);

    for (int c = 1; c < 8; c++) begin
      wr(0, 'h20 | c); wr(1, 'hFE);
      idle(2 * ratio(c) + 2);
      peek(0); chk($sformatf("R2 wrap cks%0d", c), rdata[7], 1);
    end

    wr(0, 'h20);
    for (int k = 0; k < 10; k++) begin wr(1, 0); idle(400); end
    peek(0); chk("R9 no flag", rdata[7], 0);
    wr(0, 'h68);
    for (int k = 0; k < 5; k++) begin wr(1, 'h10); idle(300); end
    peek(2); chk("R9 src kept", rdata[3], 1);
    peek(0); chk("R9 no flag wd", rdata[7], 0);

    wr(0, 'h60); wr(1, 'hFE); idle(10);
    peek(0); chk("R11 flag", rdata[7], 1); chk("R11 irq", irq, 0);
    peek(2); chk("R11 src", rdata[3], 1);

    wr(0, 'h68); wr(1, 'hFE);
    pulses = 0; irqs = 0;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (int_rst) pulses++;
      if (irq) irqs++;
    end
    chk("R5 one pulse", pulses, 1); chk("R5 no irq", irqs, 0);
    peek(2); chk("R6 cleared by watchdog", rdata[3], 0);

    wr(2, 'hFF); chk("R10 hold bits", rdata, 'hF7);
    wr(2, 'h00); chk("R10 zero", rdata, 'h00);
    ext_rst_n = 0; cyc(); ext_rst_n = 1; cyc();
    peek(2); chk("R6 set by ext reset", rdata, 'h09);
    wr(2, 'h00); chk("R6 write ignored", rdata, 'h08);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule